// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen interrupt causes and turns them into one request strobe and one vector address for a CPU core. There are three external edge pins, two counter-pin edge inputs and a key-wakeup cause. The key-wakeup cause is the AND of an eight-bit port, where pins in output mode are left out. Nine internal event pulses and a software-break request complete the set. Each maskable cause has a pending bit and an enable bit, held in byte-wide registers. A single global disable flag gates all maskable causes together.

Every cycle the block picks the highest-ranked cause that is allowed and drives `irq` together with the address of the vector's high byte. When the CPU pulses `irq_ack`, the block clears the pending bit of the cause it was presenting and sets the global disable flag. Software can clear pending bits but can never set them. Each external and counter pin has its own edge polarity. Rewriting a polarity bit is treated as a possible edge and sets that pin's pending bit.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `irq_vec` is 0, all pending, enable and polarity bits are 0, the break pending bit is 0 and the global disable flag is 1.
- R2: A maskable cause drives `irq` only when its pending bit is 1, its enable bit is 1 and the global disable flag (control register address 5, bit 0) is 0.
- R3: A register write clears each pending bit whose data bit is 0 and leaves it unchanged where the data bit is 1. Pending bits are at address 0 (causes 0..7 in bits 0..7) and address 1 (causes 8..14 in bits 0..6). A hardware set in the same cycle as a clear wins.
- R4: Cause index order is fixed and the lowest index wins. The order is: pin 0, pin 1, pin 2, events 0..7 (indices 3..10), counter pin 0 (11), counter pin 1 (12), key wakeup (13), event 8 (14), then software break last. `irq_vec` is 16'hFFFB minus 2 times the index, break gives 16'hFFDD, and no cause gives 0.
- R5: `irq_ack` while `irq` is 1 clears only the presented cause's pending bit and sets the global disable flag; all other pending causes stay pending.
- R6: Pins pass a two-flop synchronizer. Polarity bit 0 means a falling edge sets the request and 1 means a rising edge does. The polarity register is at address 4: pins 0..2 use bits 0..2, and counter pins 0 and 1 use bits 6 and 7. A new level first sampled at clock edge j shows in the pending bit after edge j+2.
- R7: A write to the polarity register that changes a pin's bit sets that pin's pending bit; writing an unchanged value sets nothing.
- R8: The key-wakeup pending bit (index 13) is set when the AND of the synchronized key pins, with every pin whose `key_dir` bit is 1 forced to 1, goes from 1 to 0.
- R9: The software break is latched into a pending bit (address 5, bit 1, read-only) regardless of enables and the disable flag. It is presented only when no allowed maskable cause exists, and it is cleared by acknowledge.
- R10: Unused bits read as 0 and ignore writes: bit 7 of addresses 1 and 3, bits 3..5 of address 4, bits 7..2 of address 5, and all of addresses 6 and 7. Enables are at address 2 (causes 0..7) and address 3 (causes 8..14).
- R11: A one-cycle pulse on `evt[k]` sets pending bit 3+k for k in 0..7, and `evt[8]` sets pending bit 14, at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_ext | input | 5 | Asynchronous edge pins: bits 0..2 external, bits 3..4 counter pins |
| key_pin | input | 8 | Asynchronous key port levels |
| key_dir | input | 8 | Key port direction, 1 = output (excluded from the AND) |
| evt | input | 9 | Internal event pulses |
| brk_req | input | 1 | Software break request pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq | output | 1 | Interrupt strobe to the CPU |
| irq_vec | output | 16 | Address of the selected vector's high byte |

## Verification
The bench targets several hazards. When causes become pending together, only the top-ranked one should clear on acknowledge; a broken encoder would serve the wrong vector or drop a lower request. A software write of 1 must not create a request, and a clear must not swallow an event arriving in the same cycle; getting either wrong shows up as a spurious interrupt or a lost one. The bench also measures synchronizer latency, polarity inversion and the request raised by rewriting a polarity bit, where a wrong design would fire on the wrong edge or a cycle early. It checks that key-port pins in output mode are excluded, and that a break gets through while everything is masked but still loses to any allowed maskable cause.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC    = 15;            // maskable causes
    localparam int NPIN    = 5;             // edge pins (3 external + 2 counter)
    localparam int NEVT    = 9;             // internal event pulses
    localparam int KEY_W   = 8;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int HI_W    = NSRC - 8;
    localparam int SRC_KEY = 13;

    localparam logic [15:0] VEC_TOP = 16'hFFFD;
    localparam logic [15:0] VEC_BRK = VEC_TOP - 16'((NSRC + 1) * 2);

    typedef enum logic [2:0] {
        RA_PEND_LO = 3'd0,
        RA_PEND_HI = 3'd1,
        RA_MASK_LO = 3'd2,
        RA_MASK_HI = 3'd3,
        RA_POL     = 3'd4,
        RA_CTRL    = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic             valid;
        logic             brk;
        logic [IDX_W-1:0] idx;
    } grant_t;

    function automatic logic [15:0] vec_of(grant_t g);
        logic [15:0] off;
        off = {{(15 - IDX_W){1'b0}}, g.idx, 1'b0};
        if (!g.valid)
            return '0;
        if (g.brk)
            return VEC_BRK;
        return VEC_TOP - 16'd2 - off;
    endfunction

endpackage

// File: rtl/irqc_pin_edge.sv
module irqc_pin_edge
    import irqc_pkg::*;
#(
    parameter int W = NPIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] pol_chg,
    output logic [W-1:0] hit
);

    logic [W-1:0] s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            s2   <= '0;
            prev <= '0;
        end else begin
            s1   <= pins;
            s2   <= s1;
            prev <= s2;
        end
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            logic rise, fall;
            assign rise   = s2[i] & ~prev[i];
            assign fall   = ~s2[i] & prev[i];
            assign hit[i] = (pol[i] ? rise : fall) | pol_chg[i];
        end
    endgenerate

endmodule

// File: rtl/irqc_key_wake.sv
module irqc_key_wake
    import irqc_pkg::*;
#(
    parameter int W = KEY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] dir,
    output logic         fall
);

    logic [W-1:0] s1, s2;
    logic         and_now, and_prev;

    assign and_now = &(s2 | dir);
    assign fall    = and_prev & ~and_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= '1;
            s2       <= '1;
            and_prev <= 1'b1;
        end else begin
            s1       <= pins;
            s2       <= s1;
            and_prev <= and_now;
        end
    end

    a_r8_fall_needs_low_and: assert property (@(posedge clk) disable iff (rst)
        fall |=> !and_prev);

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [2:0]      waddr,
    input  logic [7:0]      wdata,
    input  logic [2:0]      raddr,
    output logic [7:0]      rdata,
    input  logic [NSRC-1:0] hw_set,
    input  logic            brk_set,
    input  logic            ack,
    input  grant_t          grant,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] mask,
    output logic            dis,
    output logic            brk_pend,
    output logic [NPIN-1:0] pol,
    output logic [NPIN-1:0] pol_chg
);

    logic            take;
    logic [NSRC-1:0] ack_clr, keep, pend_d;
    logic [NPIN-1:0] wpol;

    assign take = ack & grant.valid;
    assign wpol = {wdata[7], wdata[6], wdata[2:0]};
    assign pol_chg = (we && waddr == RA_POL) ? (wpol ^ pol) : '0;

    always_comb begin
        ack_clr = '0;
        if (take && !grant.brk)
            ack_clr[grant.idx] = 1'b1;
        keep = '1;
        if (we && waddr == RA_PEND_LO)
            keep[7:0] = wdata;
        if (we && waddr == RA_PEND_HI)
            keep[NSRC-1:8] = wdata[HI_W-1:0];
        pend_d = (pend & ~ack_clr & keep) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            mask     <= '0;
            pol      <= '0;
            dis      <= 1'b1;
            brk_pend <= 1'b0;
        end else begin
            pend <= pend_d;
            if (we && waddr == RA_MASK_LO)
                mask[7:0] <= wdata;
            if (we && waddr == RA_MASK_HI)
                mask[NSRC-1:8] <= wdata[HI_W-1:0];
            if (we && waddr == RA_POL)
                pol <= wpol;
            if (take)
                dis <= 1'b1;
            else if (we && waddr == RA_CTRL)
                dis <= wdata[0];
            if (brk_set)
                brk_pend <= 1'b1;
            else if (take && grant.brk)
                brk_pend <= 1'b0;
        end
    end

    always_comb begin
        case (raddr)
            RA_PEND_LO: rdata = pend[7:0];
            RA_PEND_HI: rdata = {{(8 - HI_W){1'b0}}, pend[NSRC-1:8]};
            RA_MASK_LO: rdata = mask[7:0];
            RA_MASK_HI: rdata = {{(8 - HI_W){1'b0}}, mask[NSRC-1:8]};
            RA_POL:     rdata = {pol[4], pol[3], 3'b000, pol[2:0]};
            RA_CTRL:    rdata = {6'b0, brk_pend, dis};
            default:    rdata = '0;
        endcase
    end

    a_r3_no_software_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(hw_set)) == '0));

    a_r5_accept_sets_disable: assert property (@(posedge clk) disable iff (rst)
        take |=> dis);

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] mask,
    input  logic            dis,
    input  logic            brk_pend,
    output grant_t          grant
);

    logic [NSRC-1:0] cand, win;
    logic [NSRC:0]   above;

    assign cand     = pend & mask & {NSRC{~dis}};
    assign above[0] = 1'b0;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_chain
            assign win[i]     = cand[i] & ~above[i];
            assign above[i+1] = above[i] | cand[i];
        end
    endgenerate

    always_comb begin
        grant = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (win[i]) begin
                grant.valid = 1'b1;
                grant.idx   = IDX_W'(i);
            end
        end
        if (!above[NSRC] && brk_pend) begin
            grant.valid = 1'b1;
            grant.brk   = 1'b1;
        end
    end

    a_r4_single_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NPIN-1:0]    pin_ext,
    input  logic [KEY_W-1:0]   key_pin,
    input  logic [KEY_W-1:0]   key_dir,
    input  logic [NEVT-1:0]    evt,
    input  logic               brk_req,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic [2:0]         reg_raddr,
    output logic [7:0]         reg_rdata,
    input  logic               irq_ack,
    output logic               irq,
    output logic [15:0]        irq_vec
);

    logic [NPIN-1:0] pin_hit, pol, pol_chg;
    logic            key_fall;
    logic [NSRC-1:0] hw_set, pend, mask;
    logic            dis, brk_pend;
    grant_t          grant;

    irqc_pin_edge #(.W(NPIN)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .pins    (pin_ext),
        .pol     (pol),
        .pol_chg (pol_chg),
        .hit     (pin_hit)
    );

    irqc_key_wake #(.W(KEY_W)) u_key (
        .clk  (clk),
        .rst  (rst),
        .pins (key_pin),
        .dir  (key_dir),
        .fall (key_fall)
    );

    // Cause index order is the priority order.
    assign hw_set = {evt[8], key_fall, pin_hit[4:3], evt[7:0], pin_hit[2:0]};

    irqc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .waddr    (reg_addr),
        .wdata    (reg_wdata),
        .raddr    (reg_raddr),
        .rdata    (reg_rdata),
        .hw_set   (hw_set),
        .brk_set  (brk_req),
        .ack      (irq_ack),
        .grant    (grant),
        .pend     (pend),
        .mask     (mask),
        .dis      (dis),
        .brk_pend (brk_pend),
        .pol      (pol),
        .pol_chg  (pol_chg)
    );

    irqc_prio u_prio (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .mask     (mask),
        .dis      (dis),
        .brk_pend (brk_pend),
        .grant    (grant)
    );

    assign irq     = grant.valid;
    assign irq_vec = vec_of(grant);

    a_r2_maskable_gated: assert property (@(posedge clk) disable iff (rst)
        (irq && !grant.brk) |-> (pend[grant.idx] && mask[grant.idx] && !dis));

    a_r9_break_needs_pending: assert property (@(posedge clk) disable iff (rst)
        (irq && grant.brk) |-> brk_pend);

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [4:0]  pin_ext;
    logic [7:0]  key_pin, key_dir;
    logic [8:0]  evt;
    logic        brk_req, reg_we, irq_ack, irq;
    logic [2:0]  reg_addr, reg_raddr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [15:0] irq_vec;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur    = "R1";

    irq_vector_ctrl u0 (
        .clk(clk), .rst(rst), .pin_ext(pin_ext), .key_pin(key_pin), .key_dir(key_dir),
        .evt(evt), .brk_req(brk_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq(irq), .irq_vec(irq_vec)
    );

    // ---------------- behavioural reference ----------------
    logic [14:0] m_req, m_en;
    logic [4:0]  m_pol;
    logic        m_dis, m_brk, m_kprev;
    logic [4:0]  ehist[$];
    logic [7:0]  khist[$];

    function automatic int pick();
        for (int i = 0; i < 15; i++)
            if (m_req[i] && m_en[i] && !m_dis) return i;
        if (m_brk) return 15;
        return -1;
    endfunction

    function automatic logic [15:0] exp_vec();
        int p = pick();
        if (p < 0) return 16'h0000;
        return 16'hFFFD - 16'(2 * (p + 1));
    endfunction

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_req[7:0];
            3'd1: return {1'b0, m_req[14:8]};
            3'd2: return m_en[7:0];
            3'd3: return {1'b0, m_en[14:8]};
            3'd4: return {m_pol[4], m_pol[3], 3'b000, m_pol[2:0]};
            3'd5: return {6'b0, m_brk, m_dis};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int          p;
        logic [14:0] set, nreq;
        logic [4:0]  npol;
        logic        kand, cur_l, old_l, hit;
        if (rst) begin
            m_req = '0; m_en = '0; m_pol = '0; m_dis = 1'b1; m_brk = 1'b0; m_kprev = 1'b1;
            ehist = {5'd0, 5'd0, 5'd0, 5'd0};
            khist = {8'hFF, 8'hFF, 8'hFF, 8'hFF};
        end else begin
            ehist.push_front(pin_ext); void'(ehist.pop_back());
            khist.push_front(key_pin); void'(khist.pop_back());
            p   = pick();
            set = '0;
            for (int i = 0; i < 5; i++) begin
                cur_l = ehist[2][i];
                old_l = ehist[3][i];
                hit   = m_pol[i] ? (cur_l && !old_l) : (!cur_l && old_l);
                if (hit) set[(i < 3) ? i : i + 8] = 1'b1;
            end
            npol = m_pol;
            if (reg_we && reg_addr == 3'd4) begin
                npol = {reg_wdata[7], reg_wdata[6], reg_wdata[2:0]};
                for (int i = 0; i < 5; i++)
                    if (npol[i] != m_pol[i]) set[(i < 3) ? i : i + 8] = 1'b1;
            end
            kand = &(khist[2] | key_dir);
            if (m_kprev && !kand) set[13] = 1'b1;
            m_kprev = kand;
            for (int e = 0; e < 8; e++) if (evt[e]) set[3 + e] = 1'b1;
            if (evt[8]) set[14] = 1'b1;
            nreq = m_req;
            if (irq_ack && p >= 0 && p < 15) nreq[p] = 1'b0;
            if (reg_we && reg_addr == 3'd0) nreq[7:0]  = nreq[7:0] & reg_wdata;
            if (reg_we && reg_addr == 3'd1) nreq[14:8] = nreq[14:8] & reg_wdata[6:0];
            nreq = nreq | set;
            if (reg_we && reg_addr == 3'd2) m_en[7:0]  = reg_wdata;
            if (reg_we && reg_addr == 3'd3) m_en[14:8] = reg_wdata[6:0];
            if (reg_we && reg_addr == 3'd5) m_dis = reg_wdata[0];
            if (irq_ack && p >= 0) m_dis = 1'b1;
            if (irq_ack && p == 15) m_brk = 1'b0;
            if (brk_req) m_brk = 1'b1;
            m_req = nreq;
            m_pol = npol;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            chk(cur, "irq (model)", {15'd0, irq}, {15'd0, pick() >= 0});
            chk(cur, "irq_vec (model)", irq_vec, exp_vec());
            chk(cur, "reg_rdata (model)", {8'd0, reg_rdata}, {8'd0, exp_rd(reg_raddr)});
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_evt(logic [8:0] m);
        @(negedge clk); evt = m;
        @(negedge clk); evt = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic exp_reg(string tag, logic [2:0] a, logic [7:0] e);
        @(negedge clk); reg_raddr = a; #3;
        chk(tag, "register read", {8'd0, reg_rdata}, {8'd0, e});
    endtask

    task automatic exp_irq(string tag, logic i, logic [15:0] v);
        @(negedge clk); #3;
        chk(tag, "irq", {15'd0, irq}, {15'd0, i});
        chk(tag, "irq_vec", irq_vec, v);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, run did not complete");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; pin_ext = '0; key_pin = 8'hFF; key_dir = '0; evt = '0;
        brk_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; reg_raddr = '0;
        irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cur = "R1";
        exp_irq("R1", 1'b0, 16'h0000);
        exp_reg("R1", 3'd5, 8'h01);
        exp_reg("R1", 3'd0, 8'h00);
        exp_reg("R1", 3'd2, 8'h00);
        exp_reg("R1", 3'd4, 8'h00);

        // R11 event pulses
        cur = "R11";
        for (int e = 0; e < 9; e++) pulse_evt(9'(1 << e));
        exp_reg("R11", 3'd0, 8'hF8);
        exp_reg("R11", 3'd1, 8'h47);
        exp_irq("R11", 1'b0, 16'h0000);

        // R3 software cannot set, clear vs hardware set
        cur = "R3";
        wr(3'd0, 8'hFF);
        exp_reg("R3", 3'd0, 8'hF8);
        wr(3'd1, 8'h00);
        exp_reg("R3", 3'd1, 8'h00);
        @(negedge clk); reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00; evt = 9'h001;
        @(negedge clk); reg_we = 1'b0; evt = '0;
        exp_reg("R3", 3'd0, 8'h08);
        wr(3'd0, 8'h00);
        exp_reg("R3", 3'd0, 8'h00);

        // R2 enable and global disable gating
        cur = "R2";
        pulse_evt(9'h004);
        wr(3'd2, 8'h20);
        exp_irq("R2", 1'b0, 16'h0000);
        wr(3'd5, 8'h00);
        exp_irq("R2", 1'b1, 16'hFFF1);
        wr(3'd2, 8'h00);
        exp_irq("R2", 1'b0, 16'h0000);
        wr(3'd2, 8'h20);

        // R4 / R5 priority order and acknowledge
        cur = "R4";
        pulse_evt(9'h181);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h7F);
        exp_irq("R4", 1'b1, 16'hFFF5);
        cur = "R5";
        do_ack();
        exp_reg("R5", 3'd0, 8'h20);
        exp_reg("R5", 3'd1, 8'h44);
        exp_reg("R5", 3'd5, 8'h01);
        exp_irq("R5", 1'b0, 16'h0000);
        cur = "R4";
        wr(3'd5, 8'h00);
        exp_irq("R4", 1'b1, 16'hFFF1);
        do_ack(); wr(3'd5, 8'h00);
        exp_irq("R4", 1'b1, 16'hFFE7);
        do_ack(); wr(3'd5, 8'h00);
        exp_irq("R4", 1'b1, 16'hFFDF);
        do_ack(); wr(3'd5, 8'h00);
        exp_irq("R4", 1'b0, 16'h0000);
        wr(3'd5, 8'h01);

        // R6 polarity and latency
        cur = "R6";
        @(negedge clk); pin_ext[0] = 1'b1;
        idle(4);
        exp_reg("R6", 3'd0, 8'h00);
        @(negedge clk); pin_ext[0] = 1'b0;
        idle(4);
        exp_reg("R6", 3'd0, 8'h01);
        wr(3'd0, 8'h00);

        // R7 polarity rewrite
        cur = "R7";
        wr(3'd4, 8'h41);
        exp_reg("R7", 3'd0, 8'h01);
        exp_reg("R7", 3'd1, 8'h08);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h41);
        exp_reg("R7", 3'd0, 8'h00);
        exp_reg("R7", 3'd1, 8'h00);

        // R6 latency: level first sampled at edge j, visible after edge j+2
        cur = "R6";
        @(negedge clk); pin_ext[0] = 1'b1; reg_raddr = 3'd0;
        @(negedge clk);
        @(negedge clk); #3;
        chk("R6", "pending before latency", {8'd0, reg_rdata}, 16'h0000);
        @(negedge clk); #3;
        chk("R6", "pending after latency", {8'd0, reg_rdata}, 16'h0001);
        wr(3'd0, 8'h00);
        @(negedge clk); pin_ext[3] = 1'b1;
        idle(4);
        exp_reg("R6", 3'd1, 8'h08);
        wr(3'd1, 8'h00);
        @(negedge clk); pin_ext[3] = 1'b0;
        idle(4);
        exp_reg("R6", 3'd1, 8'h00);
        @(negedge clk); pin_ext[1] = 1'b1;
        idle(4);
        exp_reg("R6", 3'd0, 8'h00);
        @(negedge clk); pin_ext[1] = 1'b0;
        idle(4);
        exp_reg("R6", 3'd0, 8'h02);
        wr(3'd0, 8'h00);

        // R8 key wakeup with output-mode pins excluded
        cur = "R8";
        @(negedge clk); key_dir = 8'h0F;
        @(negedge clk); key_pin[1] = 1'b0;
        idle(5);
        exp_reg("R8", 3'd1, 8'h00);
        @(negedge clk); key_pin[6] = 1'b0;
        idle(5);
        exp_reg("R8", 3'd1, 8'h20);
        wr(3'd1, 8'h00);
        @(negedge clk); key_pin[6] = 1'b1;
        idle(5);
        exp_reg("R8", 3'd1, 8'h00);
        @(negedge clk); key_pin = 8'hFF;
        idle(4);

        // R9 software break
        cur = "R9";
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        @(negedge clk); brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
        exp_irq("R9", 1'b1, 16'hFFDD);
        exp_reg("R9", 3'd5, 8'h03);
        do_ack();
        exp_irq("R9", 1'b0, 16'h0000);
        exp_reg("R9", 3'd5, 8'h01);
        wr(3'd2, 8'h08);
        wr(3'd5, 8'h00);
        @(negedge clk); brk_req = 1'b1; evt = 9'h001;
        @(negedge clk); brk_req = 1'b0; evt = '0;
        exp_irq("R9", 1'b1, 16'hFFF5);
        do_ack(); wr(3'd5, 8'h00);
        exp_irq("R9", 1'b1, 16'hFFDD);
        do_ack();
        exp_reg("R9", 3'd5, 8'h01);

        // R10 unused bits
        cur = "R10";
        wr(3'd4, 8'hFF);
        exp_reg("R10", 3'd4, 8'hC7);
        wr(3'd3, 8'hFF);
        exp_reg("R10", 3'd3, 8'h7F);
        wr(3'd6, 8'hFF);
        exp_reg("R10", 3'd6, 8'h00);
        exp_reg("R10", 3'd7, 8'h00);
        wr(3'd5, 8'hFE);
        exp_reg("R10", 3'd5, 8'h00);
        wr(3'd5, 8'h01);
        idle(3);

        done = 1;
        summary();
        $finish;
    end

endmodule